// File: doc/BRIEF.md
# Attribute Table Entry Responder

This block serves read requests for a small, fixed device attribute table that arrive through a data-object mailbox. A request gives the handle of one table entry and the request length in dwords. The block checks the request and looks the entry up in a ROM built from parameters. It then streams out a response of three header dwords followed by the entry body, one dword per accepted transfer. Each response tells the requester which handle to ask for next. The last entry returns a terminal handle, so a requester can walk the whole table by following the chain.

The table describes one memory region in six entries. Handle 0 is a range descriptor. Handles 1 to 4 are performance entries, in this order: read latency, write latency, read bandwidth, write bandwidth. Handle 5 is a memory-type entry. Malformed requests are dropped without a response. While a response is in flight, the request side reports not-ready.

Top module: `tblrsp_top`

## Requirements
- R1: A request is discarded with no response when its length in dwords is below 3, the request size of 12 bytes rounded up to dwords.
- R2: A request whose handle is 6 or greater is discarded with no response.
- R3: An accepted request (req_valid high while req_ready is high) raises rsp_valid in the following cycle. req_ready stays low until the final dword has been taken. Requests presented while it is low are ignored.
- R4: Response dword 0 holds vendor ID 16'h1E98 in [15:0], object type 8'h02 in [23:16] and zero in [31:24].
- R5: Response dword 1 holds the response length in dwords, which is (12 + entry bytes + 3) / 4. The upper bits of the dword are zero. rsp_len shows the same value and holds it for the whole response. Entries 0 and 5 are 24 bytes long (9 dwords in total) and entries 1 to 4 are 18 bytes long (8 dwords in total).
- R6: Response dword 2 holds response code 8'h00 in [7:0], table type 8'h00 in [15:8] and the next handle in [31:16]. The next handle is the requested handle plus one, or 16'hFFFF for handle 5.
- R7: The entry body starts at dword 3. Body word 0 holds the entry byte length in [31:16] and the entry kind in [7:0]: 0 for range, 1 for performance, 4 for memory type. The padding bytes of the last word are zero.
- R8: Latency entries (handles 1 and 2) carry data type 1 or 2 in body word 1 [31:24], a base unit of 10000 in word 2, zero in word 3, and value 15 or 25 in word 4 [15:0].
- R9: Bandwidth entries (handles 3 and 4) carry data type 4 or 5 in body word 1 [31:24], a base unit of 1000 in word 2, zero in word 3, and value 16 in word 4 [15:0].
- R10: The range entry has flags 8'h04 (non-volatile) in body word 1 [15:8]. The memory-type entry has attribute 8'h02 in body word 1 [15:8]. Both have a zero base/offset in words 2 and 3, and the region size (low word, then high word) in words 4 and 5.
- R11: A dword advances only when rsp_valid and rsp_ready are both high, and holds while rsp_ready is low. rsp_last marks the final dword. rsp_valid drops in the cycle after that dword is taken.
- R12: After reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be sampled |
| req_len | input | LEN_W | Request length in dwords |
| req_handle | input | 16 | Requested entry handle |
| rsp_valid | output | 1 | Response dword valid |
| rsp_ready | input | 1 | Consumer takes the dword |
| rsp_data | output | 32 | Current response dword |
| rsp_last | output | 1 | Current dword is the final one |
| rsp_len | output | LEN_W | Total response length in dwords, zero when idle |

## Verification
The bench builds the block with LEN_W at its default of 10 and REGION_BYTES set to 64'h0000_0003_8000_0000. With a region that large, the high size word of the range and memory-type entries is non-zero, so a swapped or dropped word shows up. Every handle is read with and without consumer stalls. The request length is probed just below and at the 3-dword minimum. Out-of-range handles include the terminal value itself, and a valid request is injected in the middle of a response.

// File: rtl/tblrsp_pkg.sv
package tblrsp_pkg;

  localparam int NUM_ENT      = 6;
  localparam int HIDX_W       = $clog2(NUM_ENT);
  localparam int DW_BYTES     = 4;
  localparam int REQ_BYTES    = 12;
  localparam int RSP_HDR_BYTES = 12;
  localparam int MIN_REQ_DW   = (REQ_BYTES + DW_BYTES - 1) / DW_BYTES;
  localparam int RSP_HDR_DW   = (RSP_HDR_BYTES + DW_BYTES - 1) / DW_BYTES;

  localparam logic [15:0] VENDOR_ID   = 16'h1E98;
  localparam logic [7:0]  OBJ_TYPE    = 8'h02;
  localparam logic [7:0]  RSP_CODE    = 8'h00;
  localparam logic [7:0]  TBL_KIND    = 8'h00;
  localparam logic [15:0] TERM_HANDLE = 16'hFFFF;

  typedef enum logic [7:0] {
    ENT_RANGE = 8'd0,
    ENT_PERF  = 8'd1,
    ENT_MTYPE = 8'd4
  } ent_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } seq_st_e;

  function automatic ent_kind_e kind_of(input logic [HIDX_W-1:0] h);
    if (h == HIDX_W'(0))           return ENT_RANGE;
    if (h == HIDX_W'(NUM_ENT - 1)) return ENT_MTYPE;
    return ENT_PERF;
  endfunction

  function automatic logic [15:0] bytes_of(input ent_kind_e k);
    return (k == ENT_PERF) ? 16'd18 : 16'd24;
  endfunction

endpackage

// File: rtl/tblrsp_req_check.sv
module tblrsp_req_check
  import tblrsp_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [15:0]      req_handle,
  input  logic             idle,
  output logic             accept
);

  logic len_ok;
  logic hnd_ok;

  always_comb begin
    len_ok = (req_len >= LEN_W'(MIN_REQ_DW));
    hnd_ok = (req_handle < 16'(NUM_ENT));
    accept = req_valid & idle & len_ok & hnd_ok;
  end

endmodule

// File: rtl/tblrsp_rom.sv
module tblrsp_rom
  import tblrsp_pkg::*;
#(
  parameter int          LEN_W        = 10,
  parameter logic [63:0] REGION_BYTES = 64'h0000_0001_0000_0000,
  parameter logic [31:0] LAT_UNIT     = 32'd10000,
  parameter logic [31:0] BW_UNIT      = 32'd1000,
  parameter logic [15:0] RD_LAT       = 16'd15,
  parameter logic [15:0] WR_LAT       = 16'd25,
  parameter logic [15:0] RD_BW        = 16'd16,
  parameter logic [15:0] WR_BW        = 16'd16
) (
  input  logic [HIDX_W-1:0] handle,
  input  logic [LEN_W-1:0]  word_idx,
  output logic [15:0]       ent_bytes,
  output logic [31:0]       body_word
);

  logic [15:0] len_tab [NUM_ENT];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_len
    assign len_tab[e] = bytes_of(kind_of(HIDX_W'(e)));
  end

  ent_kind_e   kind;
  logic [7:0]  dtype;
  logic [31:0] unit;
  logic [15:0] value;

  always_comb begin
    kind      = kind_of(handle);
    ent_bytes = (int'(handle) < NUM_ENT) ? len_tab[handle] : 16'd0;
    unique case (handle)
      HIDX_W'(1): begin dtype = 8'd1; unit = LAT_UNIT; value = RD_LAT; end
      HIDX_W'(2): begin dtype = 8'd2; unit = LAT_UNIT; value = WR_LAT; end
      HIDX_W'(3): begin dtype = 8'd4; unit = BW_UNIT;  value = RD_BW;  end
      HIDX_W'(4): begin dtype = 8'd5; unit = BW_UNIT;  value = WR_BW;  end
      default:    begin dtype = 8'd0; unit = 32'd0;    value = 16'd0;  end
    endcase
  end

  always_comb begin
    body_word = 32'd0;
    if (word_idx == LEN_W'(0)) begin
      body_word = {ent_bytes, 8'h00, kind};
    end else begin
      unique case (kind)
        ENT_RANGE: begin
          if (word_idx == LEN_W'(1)) body_word = 32'h0000_0400;
          if (word_idx == LEN_W'(4)) body_word = REGION_BYTES[31:0];
          if (word_idx == LEN_W'(5)) body_word = REGION_BYTES[63:32];
        end
        ENT_MTYPE: begin
          if (word_idx == LEN_W'(1)) body_word = 32'h0000_0200;
          if (word_idx == LEN_W'(4)) body_word = REGION_BYTES[31:0];
          if (word_idx == LEN_W'(5)) body_word = REGION_BYTES[63:32];
        end
        ENT_PERF: begin
          if (word_idx == LEN_W'(1)) body_word = {dtype, 24'h000000};
          if (word_idx == LEN_W'(2)) body_word = unit;
          if (word_idx == LEN_W'(4)) body_word = {16'h0000, value};
        end
        default: body_word = 32'd0;
      endcase
    end
  end

endmodule

// File: rtl/tblrsp_seq.sv
module tblrsp_seq
  import tblrsp_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [HIDX_W-1:0] acc_handle,
  input  logic [15:0]       ent_bytes,
  input  logic [31:0]       body_word,
  input  logic              rsp_ready,
  output logic              idle,
  output logic [HIDX_W-1:0] handle_q,
  output logic [LEN_W-1:0]  body_idx,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_last,
  output logic [LEN_W-1:0]  rsp_len
);

  seq_st_e           state_q, state_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [HIDX_W-1:0] hnd_d;
  logic              step_en;
  logic [16:0]       byte_sum;
  logic [LEN_W-1:0]  total_dw;
  logic [15:0]       next_hnd;

  always_comb begin
    byte_sum  = 17'(ent_bytes) + 17'(RSP_HDR_BYTES) + 17'(DW_BYTES - 1);
    total_dw  = LEN_W'(byte_sum >> 2);
    next_hnd  = (handle_q == HIDX_W'(NUM_ENT - 1)) ? TERM_HANDLE
                                                   : 16'(handle_q) + 16'd1;
    idle      = (state_q == ST_IDLE);
    rsp_valid = (state_q == ST_SEND);
    rsp_len   = rsp_valid ? total_dw : '0;
    rsp_last  = rsp_valid && (idx_q == total_dw - LEN_W'(1));
    body_idx  = idx_q - LEN_W'(RSP_HDR_DW);
    if (idx_q == LEN_W'(0))      rsp_data = {8'h00, OBJ_TYPE, VENDOR_ID};
    else if (idx_q == LEN_W'(1)) rsp_data = 32'(total_dw);
    else if (idx_q == LEN_W'(2)) rsp_data = {next_hnd, TBL_KIND, RSP_CODE};
    else                         rsp_data = body_word;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    hnd_d   = handle_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SEND;
        idx_d   = '0;
        hnd_d   = acc_handle;
      end
      ST_SEND: if (rsp_ready) begin
        if (rsp_last) state_d = ST_IDLE;
        else          idx_d   = idx_q + LEN_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign step_en = accept | (rsp_valid & rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      handle_q <= '0;
    end else if (step_en) begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      handle_q <= hnd_d;
    end
  end

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid && (idx_q == '0));

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_len_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_last |=> $stable(rsp_len));

  assert_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);

endmodule

// File: rtl/tblrsp_top.sv
module tblrsp_top
  import tblrsp_pkg::*;
#(
  parameter int          LEN_W        = 10,
  parameter logic [63:0] REGION_BYTES = 64'h0000_0001_0000_0000,
  parameter logic [31:0] LAT_UNIT     = 32'd10000,
  parameter logic [31:0] BW_UNIT      = 32'd1000,
  parameter logic [15:0] RD_LAT       = 16'd15,
  parameter logic [15:0] WR_LAT       = 16'd25,
  parameter logic [15:0] RD_BW        = 16'd16,
  parameter logic [15:0] WR_BW        = 16'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  input  logic [15:0]      req_handle,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_data,
  output logic             rsp_last,
  output logic [LEN_W-1:0] rsp_len
);

  logic              idle;
  logic              accept;
  logic [HIDX_W-1:0] handle_q;
  logic [LEN_W-1:0]  body_idx;
  logic [15:0]       ent_bytes;
  logic [31:0]       body_word;

  assign req_ready = idle;

  tblrsp_req_check #(.LEN_W(LEN_W)) chk_i (
    .req_valid  (req_valid),
    .req_len    (req_len),
    .req_handle (req_handle),
    .idle       (idle),
    .accept     (accept)
  );

  tblrsp_rom #(
    .LEN_W(LEN_W), .REGION_BYTES(REGION_BYTES), .LAT_UNIT(LAT_UNIT),
    .BW_UNIT(BW_UNIT), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
    .RD_BW(RD_BW), .WR_BW(WR_BW)
  ) rom_i (
    .handle    (handle_q),
    .word_idx  (body_idx),
    .ent_bytes (ent_bytes),
    .body_word (body_word)
  );

  tblrsp_seq #(.LEN_W(LEN_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .acc_handle (req_handle[HIDX_W-1:0]),
    .ent_bytes  (ent_bytes),
    .body_word  (body_word),
    .rsp_ready  (rsp_ready),
    .idle       (idle),
    .handle_q   (handle_q),
    .body_idx   (body_idx),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_last   (rsp_last),
    .rsp_len    (rsp_len)
  );

  assert_drop_short_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid && (req_len < LEN_W'(MIN_REQ_DW)) |=> !rsp_valid);

  assert_drop_handle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid && (req_handle >= 16'(NUM_ENT)) |=> !rsp_valid);

  assert_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

// File: tb/tblrsp_top_tb_top.sv
module tblrsp_top_tb_top;

  localparam int          LEN_W  = 10;
  localparam logic [63:0] REGION = 64'h0000_0003_8000_0000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [LEN_W-1:0] req_len;
  logic [15:0]      req_handle;
  logic             rsp_valid;
  logic             rsp_ready;
  logic [31:0]      rsp_data;
  logic             rsp_last;
  logic [LEN_W-1:0] rsp_len;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;

  tblrsp_top #(.LEN_W(LEN_W), .REGION_BYTES(REGION)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .req_handle(req_handle), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rsp_len(rsp_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_bytes(input int h);
    return (h == 0 || h == 5) ? 24 : 18;
  endfunction

  function automatic int exp_len(input int h);
    return (12 + exp_bytes(h) + 3) / 4;
  endfunction

  function automatic logic [31:0] exp_body(input int h, input int w);
    logic [7:0]  kind;
    logic [7:0]  dt;
    logic [31:0] un;
    logic [15:0] v;
    kind = (h == 0) ? 8'd0 : (h == 5) ? 8'd4 : 8'd1;
    if (w == 0) return {16'(exp_bytes(h)), 8'h00, kind};
    if (h == 0 || h == 5) begin
      if (w == 1) return (h == 0) ? 32'h0000_0400 : 32'h0000_0200;
      if (w == 4) return REGION[31:0];
      if (w == 5) return REGION[63:32];
      return 32'd0;
    end
    dt = (h == 1) ? 8'd1 : (h == 2) ? 8'd2 : (h == 3) ? 8'd4 : 8'd5;
    un = (h <= 2) ? 32'd10000 : 32'd1000;
    v  = (h == 1) ? 16'd15 : (h == 2) ? 16'd25 : 16'd16;
    if (w == 1) return {dt, 24'h0};
    if (w == 2) return un;
    if (w == 4) return {16'h0, v};
    return 32'd0;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_len = '0; req_handle = '0;
    rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R12 req_ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_entry(input int h, input int len, input bit stall,
                         input bit poke);
    logic [31:0] got [16];
    logic [31:0] hold;
    bit          held;
    int          n;
    int          k;
    int          cyc;
    string       btag;
    n = exp_len(h); k = 0; cyc = 0; held = 1'b0; hold = '0;
    @(negedge clk);
    req_valid = 1'b1; req_len = LEN_W'(len); req_handle = 16'(h);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R3 start", 32'(rsp_valid), 32'd1);
    while (k < n && cyc < 200) begin
      bit rdy;
      rdy = stall ? ((cyc % 3) != 1) : 1'b1;
      if (poke && cyc == 1) begin
        chk(req_ready == 1'b0, "R3 busy", 32'(req_ready), 32'd0);
        req_valid = 1'b1; req_len = LEN_W'(3); req_handle = 16'd2;
      end
      if (poke && cyc == 2) req_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R11 valid", 32'(rsp_valid), 32'd1);
      chk(rsp_len == LEN_W'(n), "R5 rsp_len", 32'(rsp_len), 32'(n));
      if (held) chk(rsp_data == hold, "R11 hold", rsp_data, hold);
      held = 1'b0;
      if (rdy) begin
        got[k] = rsp_data;
        chk(rsp_last == (k == n - 1), "R11 last", 32'(rsp_last),
            32'(k == n - 1));
        k++;
      end else begin
        hold = rsp_data; held = 1'b1;
      end
      rsp_ready = rdy;
      @(negedge clk);
      cyc++;
    end
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R11 end", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R11 ready back", 32'(req_ready), 32'd1);
    chk(got[0] == 32'h0002_1E98, "R4 header", got[0], 32'h0002_1E98);
    chk(got[1] == 32'(n), "R5 length dword", got[1], 32'(n));
    chk(got[2] == {(h == 5) ? 16'hFFFF : 16'(h + 1), 16'h0000},
        "R6 descriptor", got[2], {(h == 5) ? 16'hFFFF : 16'(h + 1), 16'h0000});
    for (int w = 0; w < n - 3; w++) begin
      btag = (w == 0) ? "R7 body" : (h == 0 || h == 5) ? "R10 body" :
             (h <= 2) ? "R8 body" : "R9 body";
      chk(got[3 + w] == exp_body(h, w), btag, got[3 + w], exp_body(h, w));
    end
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3 ignored", 32'(rsp_valid), 32'd0);
      end
    end
  endtask

  task automatic t_drop(input int len, input int h, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_len = LEN_W'(len); req_handle = 16'(h);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, tag, 32'(rsp_valid), 32'd0);
    repeat (2) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, tag, 32'(rsp_valid), 32'd0);
    end
    chk(req_ready == 1'b1, tag, 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL R11 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    for (int h = 0; h < 6; h++) t_entry(h, 3, 1'b0, 1'b0);
    for (int h = 0; h < 6; h++) t_entry(h, 5, 1'b1, 1'b0);
    t_entry(4, 3, 1'b0, 1'b1);
    t_drop(2, 1, "R1 len2");
    t_drop(0, 0, "R1 len0");
    t_drop(3, 6, "R2 handle6");
    t_drop(4, 16'hFFFF, "R2 handleFFFF");
    t_entry(0, 3, 1'b1, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule